// File: doc/BRIEF.md
# Scheduled Parity Inverter

This unit reduces a vector of input lanes to a single parity bit and registers the result. A free-running linear feedback shift register with fixed parameters runs beside the reduction. A fixed mask parameter picks the lanes that are XORed with the matching register cell before the reduction. Together, the masked cells add a GF(2) dot product of the mask and the current register state to the true parity.

The mask is chosen off-line so that this dot product is zero for every state from the seed up to cycle u−1, and one at cycle u. Here u is the first cycle at which the register states seen since reset span the whole space. The output is therefore exact parity for the first u cycles after reset and is inverted in cycle u. After that it follows parity XOR the dot product, cycle by cycle. Because u sits near the register width, the silent stretch is short and fully set by seed, taps and mask. This makes the unit a compact, deterministic test object for logic that has to find state-dependent output corruption.

Top module: `sched_parity_inv`

## Requirements
- R1: While reset (active low, asynchronous) is asserted the output is 0, and in the first cycle after release the shift register holds the seed parameter.
- R2: Each clock the shift register moves one place toward the most significant bit. Its new bit 0 is the XOR of the state bits selected by the tap parameter. With a nonzero seed the state is never all zeros.
- R3: The output is registered: a change on the input lanes does not reach the output before the next rising clock edge.
- R4: In cycles 0 to u−1 after reset, counted in clock edges, the output taken at edge i equals the XOR of all input lanes sampled at that edge.
- R5: At edge u the output is the inverse of the parity of the lanes sampled at that edge.
- R6: With an all-zero mask, no register cell reaches any lane, and the output is always the plain input parity.
- R7: After edge u, the output at edge i equals the input parity XOR the dot product of the mask and the register state of cycle i. The inversion is not held.
- R8: Asserting reset in the middle of a run restarts the sequence, so the silent stretch of u cycles and the inversion at u happen again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lanes_in | input | W | Input lanes to be reduced |
| parity_out | output | 1 | Registered parity, possibly inverted by the masked register term |

## Verification
The bench builds three copies. The first has width 8, taps 0xB8 (a maximal-length feedback set) and seed 0x01, with the mask derived in the bench by GF(2) elimination; its inversion falls at cycle 7. The second has width 5, taps 0x14 and seed 0x03; its shorter silent stretch puts the post-inversion tracking rule in view while the wider copy is still silent. The third copy keeps the width-8 register but has an all-zero mask, so every cycle checks that unmasked lanes carry no register term.

// File: rtl/sched_parity_inv_pkg.sv
package sched_parity_inv_pkg;
  // Supported lane counts: at least two cells so that the shift has a body.
  localparam int MIN_W = 2;
  localparam int MAX_W = 32;
endpackage

// File: rtl/sched_parity_inv_lfsr.sv
module sched_parity_inv_lfsr #(
  parameter int W = 8,
  parameter logic [W-1:0] SEED = 8'h01,
  parameter logic [W-1:0] TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state_o
);
  // One Fibonacci step: shift up, feedback enters at bit 0.
  function automatic logic [W-1:0] next_state(input logic [W-1:0] s);
    logic fb;
    fb = ^(s & TAPS);
    return {s[W-2:0], fb};
  endfunction

  logic [W-1:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= next_state(state_q);
  end

  assign state_o = state_q;
endmodule

// File: rtl/sched_parity_inv_mix.sv
module sched_parity_inv_mix #(
  parameter int W = 8,
  parameter logic [W-1:0] MASK = '0
) (
  input  logic [W-1:0] lanes_i,
  input  logic [W-1:0] state_i,
  output logic [W-1:0] mixed_o,
  output logic         inject_o
);
  // GF(2) inner product of two vectors.
  function automatic logic gf2_dot(input logic [W-1:0] x, input logic [W-1:0] y);
    return ^(x & y);
  endfunction

  for (genvar j = 0; j < W; j++) begin : g_lane
    if (MASK[j]) begin : g_tap
      assign mixed_o[j] = lanes_i[j] ^ state_i[j];
    end else begin : g_pass
      assign mixed_o[j] = lanes_i[j];
    end
  end

  assign inject_o = gf2_dot(state_i, MASK);
endmodule

// File: rtl/sched_parity_inv_tree.sv
module sched_parity_inv_tree #(
  parameter int W = 8
) (
  input  logic [W-1:0] bits_i,
  output logic         par_o
);
  logic [W:0] acc;

  assign acc[0] = 1'b0;
  for (genvar j = 0; j < W; j++) begin : g_chain
    assign acc[j+1] = acc[j] ^ bits_i[j];
  end

  assign par_o = acc[W];
endmodule

// File: rtl/sched_parity_inv.sv
module sched_parity_inv #(
  parameter int W = 8,
  parameter logic [W-1:0] SEED = 8'h01,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lanes_in,
  output logic         parity_out
);
  import sched_parity_inv_pkg::*;

  if (W < MIN_W || W > MAX_W) begin : g_bad_width
    $error("sched_parity_inv: W out of supported range");
  end

  // Named internal events, observed by the bound checker.
  logic [W-1:0] lfsr_state;
  logic [W-1:0] mixed_lanes;
  logic         inject_bit;
  logic         mixed_par;
  logic         out_q;

  sched_parity_inv_lfsr #(.W(W), .SEED(SEED), .TAPS(TAPS)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_o (lfsr_state)
  );

  sched_parity_inv_mix #(.W(W), .MASK(MASK)) u_mix (
    .lanes_i  (lanes_in),
    .state_i  (lfsr_state),
    .mixed_o  (mixed_lanes),
    .inject_o (inject_bit)
  );

  sched_parity_inv_tree #(.W(W)) u_tree (
    .bits_i (mixed_lanes),
    .par_o  (mixed_par)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= mixed_par;
  end

  assign parity_out = out_q;
endmodule

// File: rtl/sched_parity_inv_chk.sv
module sched_parity_inv_chk #(
  parameter int W = 8,
  parameter logic [W-1:0] SEED = 8'h01
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] lanes_in,
  input logic         parity_out,
  input logic [W-1:0] lfsr_state,
  input logic         inject_bit
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  // R1
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (lfsr_state == SEED && parity_out == 1'b0));

  // R2
  state_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_state != '0);

  // R2
  shift_body_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> lfsr_state[W-1:1] == $past(lfsr_state[W-2:0]));

  // R4
  clean_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inject_bit |=> parity_out == $past(^lanes_in));

  // R5
  inverted_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inject_bit |=> parity_out != $past(^lanes_in));
endmodule

bind sched_parity_inv sched_parity_inv_chk #(.W(W), .SEED(SEED)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lanes_in   (lanes_in),
  .parity_out (parity_out),
  .lfsr_state (lfsr_state),
  .inject_bit (inject_bit)
);

// File: tb/test_sched_parity_inv.sv
module test_sched_parity_inv;
  localparam int CLK_P = 10;

  localparam int          WA    = 8;
  localparam logic [31:0] SEEDA = 32'h01;
  localparam logic [31:0] TAPSA = 32'hB8;
  localparam int          WB    = 5;
  localparam logic [31:0] SEEDB = 32'h03;
  localparam logic [31:0] TAPSB = 32'h14;

  // Bench-side register step: taps gathered bit by bit.
  function automatic logic [31:0] tb_step(input logic [31:0] s, input logic [31:0] taps, input int w);
    logic fb;
    logic [31:0] r;
    fb = 1'b0;
    r  = '0;
    for (int b = 0; b < w; b++) if (taps[b]) fb = fb ^ s[b];
    for (int b = w - 1; b > 0; b--) r[b] = s[b-1];
    r[0] = fb;
    return r;
  endfunction

  function automatic logic tb_dot(input logic [31:0] x, input logic [31:0] y, input int w);
    logic acc;
    acc = 1'b0;
    for (int b = 0; b < w; b++) acc = acc ^ (x[b] & y[b]);
    return acc;
  endfunction

  function automatic int tb_rank(input logic [31:0] have);
    int n;
    n = 0;
    for (int b = 0; b < 32; b++) if (have[b]) n++;
    return n;
  endfunction

  // GF(2) elimination over the state sequence. Sel=0 returns the mask,
  // sel=1 returns u (index where the span becomes full).
  function automatic logic [31:0] tb_solve(input logic [31:0] seed, input logic [31:0] taps,
                                           input int w, input bit sel);
    logic [31:0][31:0] basis;
    logic [31:0] have, x, r, v;
    logic placed, got_v, free_used;
    int u_idx;
    basis = '0; have = '0; r = seed; v = '0;
    got_v = 1'b0; u_idx = -1;
    for (int i = 0; i < 4 * w; i++) begin
      if (u_idx < 0) begin
        x = r; placed = 1'b0;
        for (int c = 31; c >= 0; c--) begin
          if (!placed && x[c]) begin
            if (have[c]) x = x ^ basis[c];
            else begin basis[c] = x; have[c] = 1'b1; placed = 1'b1; end
          end
        end
        if (!got_v && tb_rank(have) == w - 1) begin
          free_used = 1'b0;
          for (int c = 0; c < w; c++) begin
            if (have[c]) v[c] = ^(basis[c] & v);
            else if (!free_used) begin v[c] = 1'b1; free_used = 1'b1; end
          end
          got_v = 1'b1;
        end
        if (tb_rank(have) == w) u_idx = i;
        r = tb_step(r, taps, w);
      end
    end
    return sel ? 32'(u_idx) : v;
  endfunction

  localparam logic [31:0] MASKA = tb_solve(SEEDA, TAPSA, WA, 1'b0);
  localparam logic [31:0] MASKB = tb_solve(SEEDB, TAPSB, WB, 1'b0);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [WA-1:0] lanes = '0;
  logic          ya, yb, yn;

  int total = 0;
  int bad = 0;
  int ua, ub, idx;
  logic [31:0] ma, mb;
  logic prev_a, prev_b, prev_n;

  always #(CLK_P / 2) clk = ~clk;

  sched_parity_inv #(.W(WA), .SEED(SEEDA[WA-1:0]), .TAPS(TAPSA[WA-1:0]), .MASK(MASKA[WA-1:0]))
    i_sched_parity_inv (.clk(clk), .rst_n(rst_n), .lanes_in(lanes), .parity_out(ya));

  sched_parity_inv #(.W(WB), .SEED(SEEDB[WB-1:0]), .TAPS(TAPSB[WB-1:0]), .MASK(MASKB[WB-1:0]))
    i_sched_parity_inv_w5 (.clk(clk), .rst_n(rst_n), .lanes_in(lanes[WB-1:0]), .parity_out(yb));

  sched_parity_inv #(.W(WA), .SEED(SEEDA[WA-1:0]), .TAPS(TAPSA[WA-1:0]), .MASK('0))
    i_sched_parity_inv_nomask (.clk(clk), .rst_n(rst_n), .lanes_in(lanes), .parity_out(yn));

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b (cycle %0d)", req, act, exp, idx);
    end
  endtask

  // R1: output low in reset; models reload the seed.
  task automatic t_reset_state();
    rst_n = 1'b0;
    lanes = '0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset output w8", ya, 1'b0);
    check("R1 reset output w5", yb, 1'b0);
    check("R1 reset output nomask", yn, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    ma = SEEDA; mb = SEEDB; idx = 0;
    prev_a = 1'b0; prev_b = 1'b0; prev_n = 1'b0;
  endtask

  function automatic string phase(input int i, input int u);
    if (i < u)  return "R4 silent window";
    if (i == u) return "R5 inversion at u";
    return "R7 tracking after u";
  endfunction

  // One clock: drive lanes, R3 hold check, then per-copy expectation.
  task automatic step(input logic [WA-1:0] v);
    logic pa, pb, ea, eb;
    #1;
    lanes = v;
    #1;
    check("R3 no change before edge w8", ya, prev_a);
    check("R3 no change before edge w5", yb, prev_b);
    @(posedge clk);
    #1;
    pa = ^v;
    pb = ^v[WB-1:0];
    // R2: ma/mb step as the shift register does
    ea = pa ^ tb_dot(ma, MASKA, WA);
    eb = pb ^ tb_dot(mb, MASKB, WB);
    check({phase(idx, ua), " w8"}, ya, ea);
    check({phase(idx, ub), " w5"}, yb, eb);
    if (idx < ua) check("R4 plain parity w8", ya, pa);
    if (idx == ua) check("R5 inverted parity w8", ya, ~pa);
    if (idx == ub) check("R5 inverted parity w5", yb, ~pb);
    check("R6 unmasked copy is plain parity", yn, pa);
    prev_a = ea; prev_b = eb; prev_n = pa;
    ma = tb_step(ma, TAPSA, WA);
    mb = tb_step(mb, TAPSB, WB);
    idx++;
  endtask

  task automatic t_window();
    for (int k = 0; k < ua; k++) step(WA'($urandom));
  endtask

  task automatic t_trigger();
    step(WA'($urandom));
  endtask

  task automatic t_after();
    step('1);
    step('0);
    step(8'h80);
    for (int k = 0; k < 40; k++) step(WA'($urandom));
  endtask

  // R8: reset mid-run and repeat the window and the inversion.
  task automatic t_restart();
    for (int k = 0; k < 3; k++) step(WA'($urandom));
    t_reset_state();
    for (int k = 0; k <= ua; k++) step(WA'($urandom));
    check("R8 cycle count after restart", (idx == ua + 1), 1'b1);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired at cycle %0d", idx);
    finish_run();
  end

  initial begin
    ua = int'(tb_solve(SEEDA, TAPSA, WA, 1'b1));
    ub = int'(tb_solve(SEEDB, TAPSB, WB, 1'b1));
    idx = 0;
    $display("u for w8 = %0d, u for w5 = %0d", ua, ub);
    t_reset_state();
    t_window();
    t_trigger();
    t_after();
    t_restart();
    t_after();
    finish_run();
  end
endmodule